// File: doc/BRIEF.md
# Soft-Start Ramp and Overcurrent Hiccup Sequencer

This block sequences start-up and fault recovery for a digitally assisted buck PWM controller. It holds the power stage off until the bias-supply monitor reports good. It then drives a reference code that climbs one step at a time from zero to full scale. The PWM loop clamps its reference to this code, so the duty cycle widens gradually. Once the code reaches full scale the block settles in a steady running state.

An overcurrent indication turns the gate-enable output off in the same cycle. The block then enters a hiccup delay. The internal ramp runs through three complete silent soft-start periods with the outputs held off. A fourth period follows as a real restart ramp with the outputs on. If the fault is sensed again during the restart, or later while running, the whole delay repeats, with no limit on how many times. Loss of the bias-supply monitor returns the block to idle from any state.

The ramp code is `CODE_W` bits wide and advances once every `STEP_CLKS` clocks. One soft-start period therefore lasts `STEP_CLKS * (2**CODE_W - 1)` clocks. Both parameters are chosen to give the target duration of about 6.5 ms at the system clock.

Top module: `ss_hiccup_seq`

## Requirements
- R1: Synchronous reset gives seq_state 0 (idle), ramp_code 0, gate_en 0 and delay_idx 0. por_ok sampled low at a clock edge in any state gives idle with ramp_code 0 and delay_idx 0 after that edge. gate_en is low in any cycle in which por_ok is low.
- R2: In idle, por_ok sampled high moves the block to seq_state 1 (ramp) at that edge, with ramp_code 0.
- R3: In ramp (state 1) and restart ramp (state 4), ramp_code equals j after j*STEP_CLKS clocks spent in that state. The code rises by exactly one per step.
- R4: When ramp_code reaches full scale (2**CODE_W-1) the block enters seq_state 2 (run). In run the code holds at full scale.
- R5: gate_en is high exactly when the state is 1, 2 or 4, oc_detect is low and por_ok is high. A high oc_detect drops gate_en in the same cycle, before any clock edge.
- R6: oc_detect sampled high in state 1, 2 or 4 moves the block to seq_state 3 (hiccup delay) at that edge. ramp_code and delay_idx both restart from 0.
- R7: In hiccup delay the internal ramp keeps stepping with gate_en low. At the end of each period it returns to 0, and delay_idx counts 0, 1, 2. oc_detect has no effect on this state.
- R8: At the end of the third delay period the block enters seq_state 4 (restart ramp) with ramp_code 0 and delay_idx 0. It ramps as in R3 and then enters run.
- R9: oc_detect during a restart ramp starts a new three-period delay from delay_idx 0. This repeats for every new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| oc_detect | input | 1 | Overcurrent comparator output |
| ramp_code | output | CODE_W | Soft-start reference clamp code |
| gate_en | output | 1 | Switching outputs allowed |
| seq_state | output | 3 | 0 idle, 1 ramp, 2 run, 3 hiccup delay, 4 restart ramp |
| delay_idx | output | 2 | Index of the current hiccup delay period |

## Verification
The bench first targets the timing of each hiccup delay period. A design that counted the periods wrongly would restart after two or four silent ramps, and the exit from delay would land on the wrong cycle. It drives overcurrent in the same cycle as it checks gate_en; a design that registered the shutdown would keep the gates on for one extra cycle. Faults are also injected during a restart ramp and during the delay itself. A design that kept the old period count would cut the second delay short, and one that reacted to faults in delay would restart its count. Random bias-supply drops check that every state falls back to idle with the code cleared.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_RAMP    = 3'd1,
        SQ_RUN     = 3'd2,
        SQ_DELAY   = 3'd3,
        SQ_RESTART = 3'd4
    } sq_state_e;

    // silent soft-start periods before a restart ramp
    localparam int unsigned DELAY_PERIODS = 3;

    typedef struct packed {
        logic clr;   // force prescaler and code to zero
        logic run;   // prescaler counts, code may step
        logic wrap;  // at full scale return to zero instead of holding
    } ramp_ctl_t;

    function automatic logic state_drives_gate(sq_state_e s);
        return (s == SQ_RAMP) || (s == SQ_RUN) || (s == SQ_RESTART);
    endfunction

    function automatic logic state_steps_ramp(sq_state_e s);
        return (s == SQ_RAMP) || (s == SQ_DELAY) || (s == SQ_RESTART);
    endfunction

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int unsigned STEP_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic step
);
    localparam int unsigned DIV_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CLKS - 1);

    logic [DIV_W-1:0] div_q;

    assign step = run && (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter
    import ss_seq_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ramp_ctl_t         ctl,
    input  logic              step,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam logic [CODE_W-1:0] CODE_TOP  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_PREV = CODE_TOP - 1'b1;

    logic [CODE_W-1:0] code_q;

    assign code = code_q;
    assign done = step && (code_q == CODE_PREV);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            code_q <= '0;
        end else if (step) begin
            if (code_q == CODE_PREV) begin
                code_q <= ctl.wrap ? '0 : CODE_TOP;
            end else if (code_q != CODE_TOP) begin
                code_q <= code_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_hiccup_fsm.sv
module ss_hiccup_fsm
    import ss_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      por_ok,
    input  logic      oc_detect,
    input  logic      ramp_done,
    output sq_state_e state,
    output logic [1:0] delay_idx,
    output ramp_ctl_t ctl
);
    localparam logic [1:0] IDX_LAST = 2'(DELAY_PERIODS - 1);

    sq_state_e  state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic       fault_entry;

    assign state     = state_q;
    assign delay_idx = idx_q;

    assign fault_entry = oc_detect && state_drives_gate(state_q);

    // ramp control depends on state and inputs only
    always_comb begin
        ctl.clr  = !por_ok || (state_q == SQ_IDLE) || fault_entry;
        ctl.run  = por_ok && !fault_entry && state_steps_ramp(state_q);
        ctl.wrap = (state_q == SQ_DELAY);
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (!por_ok) begin
            state_d = SQ_IDLE;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    state_d = SQ_RAMP;
                    idx_d   = '0;
                end
                SQ_RAMP, SQ_RESTART: begin
                    if (oc_detect) begin
                        state_d = SQ_DELAY;
                        idx_d   = '0;
                    end else if (ramp_done) begin
                        state_d = SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (oc_detect) begin
                        state_d = SQ_DELAY;
                        idx_d   = '0;
                    end
                end
                SQ_DELAY: begin
                    if (ramp_done) begin
                        if (idx_q == IDX_LAST) begin
                            state_d = SQ_RESTART;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = SQ_IDLE;
                    idx_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq
    import ss_seq_pkg::*;
#(
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned STEP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_ok,
    input  logic              oc_detect,
    output logic [CODE_W-1:0] ramp_code,
    output logic              gate_en,
    output logic [2:0]        seq_state,
    output logic [1:0]        delay_idx
);
    sq_state_e st;
    ramp_ctl_t ctl;
    logic      step;
    logic      done;

    ss_step_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.clr),
        .run  (ctl.run),
        .step (step)
    );

    ss_ramp_counter #(.CODE_W(CODE_W)) u_ramp (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .step (step),
        .code (ramp_code),
        .done (done)
    );

    ss_hiccup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .por_ok    (por_ok),
        .oc_detect (oc_detect),
        .ramp_done (done),
        .state     (st),
        .delay_idx (delay_idx),
        .ctl       (ctl)
    );

    assign seq_state = st;
    // shutdown is combinational so a fault never waits for an edge
    assign gate_en   = state_drives_gate(st) && por_ok && !oc_detect;
endmodule

// File: rtl/ss_hiccup_seq_chk.sv
module ss_hiccup_seq_chk #(
    parameter int unsigned CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              por_ok,
    input logic              oc_detect,
    input logic [CODE_W-1:0] ramp_code,
    input logic              gate_en,
    input logic [2:0]        seq_state,
    input logic [1:0]        delay_idx
);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    a_r1_por_loss: assert property (@(posedge clk) disable iff (rst)
        !por_ok |=> (seq_state == 3'd0 && ramp_code == '0 && delay_idx == 2'd0));

    a_r3_ramp_monotonic: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd1 && $past(seq_state) == 3'd1) |-> (ramp_code >= $past(ramp_code)));

    a_r4_run_full_scale: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd2) |-> (ramp_code == FULL));

    a_r5_fault_gates_off: assert property (@(posedge clk) disable iff (rst)
        oc_detect |-> !gate_en);

    a_r6_fault_entry: assert property (@(posedge clk) disable iff (rst)
        (por_ok && oc_detect && (seq_state == 3'd1 || seq_state == 3'd2 || seq_state == 3'd4))
        |=> (seq_state == 3'd3 && ramp_code == '0 && delay_idx == 2'd0));

    a_r7_delay_silent: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd3) |-> !gate_en);

    a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
        delay_idx <= 2'd2);

    a_r8_restart_from_delay: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd4 && $past(seq_state) != 3'd4) |-> ($past(seq_state) == 3'd3 && ramp_code == '0));
endmodule

bind ss_hiccup_seq ss_hiccup_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .por_ok    (por_ok),
    .oc_detect (oc_detect),
    .ramp_code (ramp_code),
    .gate_en   (gate_en),
    .seq_state (seq_state),
    .delay_idx (delay_idx)
);

// File: tb/ss_hiccup_seq_bench.sv
`timescale 1ns/1ps
module ss_hiccup_seq_bench;
    localparam int CODE_W = 6;
    localparam int K      = 4;
    localparam int FULL   = (1 << CODE_W) - 1;
    localparam int PER    = FULL * K;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_ok = 1'b0;
    logic oc_detect = 1'b0;
    logic [CODE_W-1:0] ramp_code;
    logic gate_en;
    logic [2:0] seq_state;
    logic [1:0] delay_idx;

    int n_run  = 0;
    int n_fail = 0;
    int m_mode = 0;   // expected state code
    int m_t    = 0;   // clocks since entering that state
    bit done_f = 0;

    always #5 clk = ~clk;

    ss_hiccup_seq #(.CODE_W(CODE_W), .STEP_CLKS(K)) u_ss_hiccup_seq (
        .clk(clk), .rst(rst), .por_ok(por_ok), .oc_detect(oc_detect),
        .ramp_code(ramp_code), .gate_en(gate_en),
        .seq_state(seq_state), .delay_idx(delay_idx)
    );

    function automatic int exp_code(int mode, int t);
        case (mode)
            1, 4:    return t / K;
            2:       return FULL;
            3:       return (t % PER) / K;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_idx(int mode, int t);
        return (mode == 3) ? t / PER : 0;
    endfunction

    function automatic bit exp_gate(int mode, bit p, bit o);
        return (mode == 1 || mode == 2 || mode == 4) && p && !o;
    endfunction

    function automatic string tag_of(int mode, int t);
        case (mode)
            0: return "R1";
            1: return (t == 0) ? "R2" : "R3";
            2: return "R4";
            3: return (t == 0) ? "R6" : "R7";
            default: return (t == 0) ? "R8" : "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string tg;
        tg = tag_of(m_mode, m_t);
        chk(tg, "seq_state", int'(seq_state), m_mode);
        chk(tg, "ramp_code", int'(ramp_code), exp_code(m_mode, m_t));
        chk(tg, "delay_idx", int'(delay_idx), exp_idx(m_mode, m_t));
        chk("R5", "gate_en", int'(gate_en), int'(exp_gate(m_mode, por_ok, oc_detect)));
    endtask

    // reference timeline, advanced once per clock edge from the sampled inputs
    task automatic model_edge(bit p, bit o);
        if (!p) begin
            m_mode = 0; m_t = 0;
        end else begin
            case (m_mode)
                0: begin m_mode = 1; m_t = 0; end
                1, 4: begin
                    if (o) begin m_mode = 3; m_t = 0; end
                    else begin
                        m_t++;
                        if (m_t == PER) begin m_mode = 2; m_t = 0; end
                    end
                end
                2: if (o) begin m_mode = 3; m_t = 0; end
                default: begin
                    m_t++;
                    if (m_t == 3 * PER) begin m_mode = 4; m_t = 0; end
                end
            endcase
        end
    endtask

    task automatic cyc(bit p, bit o);
        @(negedge clk);
        por_ok = p;
        oc_detect = o;
        #1;
        if (!done_f) chk("R5", "gate_en pre-edge", int'(gate_en),
                         int'(exp_gate(m_mode, p, o)));
        @(posedge clk);
        model_edge(p, o);
        #1;
        if (!done_f) check_all();
    endtask

    task automatic cycles(int n, bit p, bit o);
        for (int i = 0; i < n; i++) cyc(p, o);
    endtask

    initial begin
        #1_500_000;
        if (!done_f) begin
            done_f = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "reset seq_state", int'(seq_state), 0);
        chk("R1", "reset ramp_code", int'(ramp_code), 0);
        chk("R1", "reset gate_en", int'(gate_en), 0);
        chk("R1", "reset delay_idx", int'(delay_idx), 0);
        @(negedge clk);
        rst = 1'b0;

        cycles(3, 1'b0, 1'b0);           // R1: stays idle without por_ok
        cycles(PER + 10, 1'b1, 1'b0);    // R2 entry, R3 ramp, R4 run
        cyc(1'b1, 1'b1);                 // R6 fault in run
        cycles(30, 1'b1, 1'b0);
        cycles(5, 1'b1, 1'b1);           // R7 fault ignored during delay
        cycles(3 * PER, 1'b1, 1'b0);     // R8 reaches restart
        cycles(20, 1'b1, 1'b0);
        cyc(1'b1, 1'b1);                 // R9 fault in restart ramp
        cycles(3 * PER + PER + 10, 1'b1, 1'b0); // full second hiccup to run
        cyc(1'b1, 1'b1);                 // R6 again
        cycles(PER + 7, 1'b1, 1'b0);
        cyc(1'b0, 1'b0);                 // R1 por loss in delay
        cycles(PER / 2, 1'b1, 1'b0);
        cyc(1'b1, 1'b1);                 // R6 fault during first ramp

        // constrained random: rare supply drops, bursts of faults
        for (int i = 0; i < 40000; i++) begin
            bit p, o;
            p = ($urandom % 1500) != 0;
            o = ($urandom % 250) == 0;
            cyc(p, o);
        end

        done_f = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule